// File: doc/BRIEF.md
# Backplane-Aware Seven-Segment Digit Decoder

This block turns the raw drive levels of one seven-segment liquid-crystal digit back into the digit it shows. The segment lines and the common (backplane) line are sampled together as one 8-bit word. Such a display is driven with alternating current: while the common line is low, a lit segment reads 1. While the common line is high, the whole pattern arrives complemented. The decoder undoes that inversion using the common bit of the same word. It then matches the result against the ten digit shapes. When a shape matches, the decoder reports the digit as a 4-bit BCD value and also as a 5-bit compact code.

A build-time parameter selects how the match is made. In full mode, all seven segments must agree with a digit shape. In reduced mode, only segments a, b, e, f and g are compared, and segments c and d are ignored. Those five segments are enough to tell all ten digits apart.

The outputs are registered on an input strobe, so each result appears one clock after its word. A word that matches no digit clears the valid flag, and the last good digit stays on the outputs. Choosing when to sample the display lines, and checking that several digits agree with each other, are left to the logic around the block.

Top module: `seg_drive_decoder`

## Requirements
- R1: After reset, `bcd_out` is 0, `valid_out` is 0 and `compact_out` is 0.
- R2: The input word is ordered common at bit 7, then segments a, b, c, d, e, f, g at bits 6 down to 0. With the common bit 0, a strobed word decodes as follows (segments listed a..g): 1111110→0, 0110000→1, 1101101→2, 1111001→3, 0110011→4, 1011011→5, 1011111→6, 1110000→7, 1111111→8, 1111011→9. The decoded word sets `valid_out` to 1 and `bcd_out` to the digit.
- R3: With the common bit 1, the word is decoded to the same digit when every segment bit is the complement of the R2 pattern for that digit.
- R4: A strobed word that, after the polarity correction, matches no digit sets `valid_out` to 0 and leaves `bcd_out` and `compact_out` at their previous values.
- R5: While `in_strobe` is low, all outputs hold their values, whatever `drive_word` does.
- R6: A word strobed at a rising clock edge is visible on the outputs just after that same edge. The outputs do not change before that edge.
- R7: On a valid decode, `compact_out` holds the polarity-corrected segments {a, b, e, f, g}, with a at bit 4 and g at bit 0. For digits 0 to 9 these values are 1E, 08, 1D, 19, 0B, 13, 17, 18, 1F, 1B in hexadecimal.
- R8: With `REDUCED_MODE`=1, segments c and d are ignored. A word whose a, b, e, f and g match a digit decodes to that digit even when c or d disagrees with the digit's shape.
- R9: With `REDUCED_MODE`=0, a word that differs from a digit shape only in segment c or segment d is rejected as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_strobe | input | 1 | Capture `drive_word` at this clock edge |
| drive_word | input | 8 | Raw levels: bit 7 is the common line, bits 6..0 are segments a..g |
| bcd_out | output | 4 | Last digit decoded successfully |
| valid_out | output | 1 | 1 when the last strobed word matched a digit |
| compact_out | output | 5 | Compact code {a,b,e,f,g} of the last good digit |

## Verification
The ten digit shapes are applied with the common line low, and again complemented with the common line high. This shows that the polarity correction and the shape matching work independently of each other. Words that match no digit are sent after a good digit, so the tests can tell a held output from one that was cleared or overwritten. Words that are correct except for segment c or d go to a full-mode instance and a reduced-mode instance at the same time: the full-mode instance must reject them and the reduced-mode instance must accept them. Separate probes wiggle the input with no strobe, and look at the outputs just before the capturing edge, to pin down when the outputs may change.

// File: rtl/seg_dec_pkg.sv
// Package: seg_dec_pkg
// Shared constants and pure functions for the seven-segment decoder.
// Segment vectors are 7 bits wide: bit 6 = a ... bit 0 = g.
// Assumes the digit shapes of a common seven-segment font.
package seg_dec_pkg;

    localparam int unsigned NUM_DIGITS = 10;
    localparam int unsigned SEG_W      = 7;
    localparam int unsigned BCD_W      = 4;
    localparam int unsigned CODE_W     = 5;
    localparam int unsigned WORD_W     = SEG_W + 1;

    // Segments that take part in the reduced comparison: a, b, e, f, g.
    localparam logic [SEG_W-1:0] REDUCED_MASK = 7'b1100111;
    localparam logic [SEG_W-1:0] FULL_MASK    = 7'b1111111;

    // Lit-segment shape of a digit, in a..g order.
    function automatic logic [SEG_W-1:0] digit_shape(input int unsigned d);
        logic [SEG_W-1:0] s;
        case (d)
            0:       s = 7'b1111110;
            1:       s = 7'b0110000;
            2:       s = 7'b1101101;
            3:       s = 7'b1111001;
            4:       s = 7'b0110011;
            5:       s = 7'b1011011;
            6:       s = 7'b1011111;
            7:       s = 7'b1110000;
            8:       s = 7'b1111111;
            9:       s = 7'b1111011;
            default: s = '0;
        endcase
        return s;
    endfunction

    // Compact code: the distinguishing subset {a,b,e,f,g}.
    function automatic logic [CODE_W-1:0] compact_of(input logic [SEG_W-1:0] s);
        return {s[6], s[5], s[2], s[1], s[0]};
    endfunction

endpackage

// File: rtl/seg_polarity_norm.sv
// Module: seg_polarity_norm
// Removes the alternating-drive inversion. When the common bit is
// high the segment bits arrive complemented; they are flipped back so
// that a lit segment always reads 1. Purely combinational.
module seg_polarity_norm
    import seg_dec_pkg::*;
(
    input  logic [WORD_W-1:0] drive_word,
    output logic [SEG_W-1:0]  lit_seg
);

    logic common_lvl;

    // Split the common line from the segment lines.
    assign common_lvl = drive_word[WORD_W-1];

    // Flip every segment when the common line is high.
    always_comb begin
        lit_seg = drive_word[SEG_W-1:0] ^ {SEG_W{common_lvl}};
    end

endmodule

// File: rtl/seg_shape_match.sv
// Module: seg_shape_match
// Compares corrected segments against every digit shape in parallel.
// REDUCED_MODE picks which segments are compared. Assumes the shapes
// stay distinct under the chosen mask, so at most one hit is set.
module seg_shape_match
    import seg_dec_pkg::*;
#(
    parameter bit REDUCED_MODE = 1'b0
) (
    input  logic [SEG_W-1:0]      lit_seg,
    output logic [NUM_DIGITS-1:0] digit_hit
);

    localparam logic [SEG_W-1:0] CMP_MASK = REDUCED_MODE ? REDUCED_MASK : FULL_MASK;

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        localparam logic [SEG_W-1:0] SHAPE = digit_shape(d);
        // One comparator per digit, only on masked segments.
        always_comb begin
            digit_hit[d] = ((lit_seg ^ SHAPE) & CMP_MASK) == '0;
        end
    end

endmodule

// File: rtl/seg_hit_encode.sv
// Module: seg_hit_encode
// Turns the one-hot hit vector into a BCD value plus an "any" flag.
// Uses an OR tree, not a priority chain; assumes at most one hit.
module seg_hit_encode
    import seg_dec_pkg::*;
(
    input  logic [NUM_DIGITS-1:0] digit_hit,
    output logic [BCD_W-1:0]      bcd_val,
    output logic                  any_hit
);

    // OR together the indices of the set hit bits.
    always_comb begin
        bcd_val = '0;
        for (int unsigned i = 0; i < NUM_DIGITS; i++) begin
            if (digit_hit[i]) bcd_val = bcd_val | BCD_W'(i);
        end
    end

    // Report whether any digit matched.
    assign any_hit = |digit_hit;

endmodule

// File: rtl/seg_drive_decoder.sv
// Module: seg_drive_decoder (top)
// Decodes one raw LCD digit drive word (common + a..g) into BCD, a
// valid flag and a 5-bit compact code. The outputs are registered on
// in_strobe, one clock of latency. A word with no match clears valid
// and keeps the last digit. Assumes in_strobe is issued only when the
// drive lines have settled.
module seg_drive_decoder
    import seg_dec_pkg::*;
#(
    parameter bit REDUCED_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_strobe,
    input  logic [WORD_W-1:0] drive_word,
    output logic [BCD_W-1:0]  bcd_out,
    output logic              valid_out,
    output logic [CODE_W-1:0] compact_out
);

    logic [SEG_W-1:0]      lit_seg;
    logic [NUM_DIGITS-1:0] digit_hit;
    logic [BCD_W-1:0]      bcd_next;
    logic                  hit_any;

    seg_polarity_norm u_norm (
        .drive_word (drive_word),
        .lit_seg    (lit_seg)
    );

    seg_shape_match #(.REDUCED_MODE(REDUCED_MODE)) u_match (
        .lit_seg   (lit_seg),
        .digit_hit (digit_hit)
    );

    seg_hit_encode u_enc (
        .digit_hit (digit_hit),
        .bcd_val   (bcd_next),
        .any_hit   (hit_any)
    );

    // Output registers: update on strobe; keep the digit on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_out     <= '0;
            valid_out   <= 1'b0;
            compact_out <= '0;
        end else if (in_strobe) begin
            valid_out <= hit_any;
            if (hit_any) begin
                bcd_out     <= bcd_next;
                compact_out <= compact_of(lit_seg);
            end
        end
    end

endmodule

// File: rtl/seg_drive_decoder_chk.sv
// Module: seg_drive_decoder_chk
// Assertion checker bound to seg_drive_decoder.
module seg_drive_decoder_chk
    import seg_dec_pkg::*;
#(
    parameter bit REDUCED_MODE = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_strobe,
    input logic [BCD_W-1:0]      bcd_out,
    input logic                  valid_out,
    input logic [CODE_W-1:0]     compact_out,
    input logic [NUM_DIGITS-1:0] digit_hit
);

    // The shape comparators never report two digits at once (R2).
    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_hit));

    // A valid result always carries a decimal digit (R2).
    assert_bcd_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (bcd_out < BCD_W'(NUM_DIGITS)));

    // Outputs do not move without a strobe (R5).
    assert_hold_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_strobe |=> ($stable(bcd_out) && $stable(valid_out) && $stable(compact_out)));

    // A strobed hit shows as valid after the edge (R6).
    assert_hit_sets_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && (digit_hit != '0)) |=> valid_out);

    // A strobed miss clears valid and keeps the digit (R4).
    assert_miss_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && (digit_hit == '0)) |=> (!valid_out && $stable(bcd_out) && $stable(compact_out)));

    // Compact code agrees with the reported digit (R7).
    assert_compact_agrees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (compact_out == compact_of(digit_shape(int'(bcd_out)))));

endmodule

bind seg_drive_decoder seg_drive_decoder_chk #(.REDUCED_MODE(REDUCED_MODE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_strobe   (in_strobe),
    .bcd_out     (bcd_out),
    .valid_out   (valid_out),
    .compact_out (compact_out),
    .digit_hit   (digit_hit)
);

// File: tb/test_seg_drive_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them. Instance 0 is full mode, instance 1 is reduced mode.
module test_seg_drive_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_strobe = 1'b0;
    logic [7:0] drive_word = 8'h00;

    logic [3:0] bcd_f, bcd_r;
    logic       val_f, val_r;
    logic [4:0] cmp_f, cmp_r;

    int total = 0;
    int bad = 0;
    bit pending = 1'b0;

    typedef struct packed {
        logic [3:0] bcd;
        logic       val;
        logic [4:0] cmp;
    } exp_t;

    exp_t  exp_q [2][$];
    string tag_q [$];

    logic [3:0] mdl_bcd [2];
    logic [4:0] mdl_cmp [2];

    always #2.5 clk = ~clk;

    seg_drive_decoder #(.REDUCED_MODE(1'b0)) i_seg_drive_decoder (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .drive_word(drive_word),
        .bcd_out(bcd_f), .valid_out(val_f), .compact_out(cmp_f));

    seg_drive_decoder #(.REDUCED_MODE(1'b1)) i_seg_drive_decoder_red (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .drive_word(drive_word),
        .bcd_out(bcd_r), .valid_out(val_r), .compact_out(cmp_r));

    // Bench copy of the digit shapes, from the requirements.
    function automatic logic [6:0] shape(input int d);
        case (d)
            0: return 7'b1111110;
            1: return 7'b0110000;
            2: return 7'b1101101;
            3: return 7'b1111001;
            4: return 7'b0110011;
            5: return 7'b1011011;
            6: return 7'b1011111;
            7: return 7'b1110000;
            8: return 7'b1111111;
            default: return 7'b1111011;
        endcase
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got bcd=%0h val=%0b cmp=%0h, expected bcd=%0h val=%0b cmp=%0h",
                     tag, act[9:6], act[5], act[4:0], exp[9:6], exp[5], exp[4:0]);
        end
    endtask

    // Driver: apply one strobed word and push the expected results.
    task automatic apply(input logic [7:0] w, input string tag);
        logic [6:0] seg;
        seg = w[6:0] ^ {7{w[7]}};
        for (int m = 0; m < 2; m++) begin
            logic [6:0] mask;
            bit hit;
            mask = (m == 1) ? 7'b1100111 : 7'b1111111;
            hit = 1'b0;
            for (int d = 0; d < 10; d++) begin
                if (((seg ^ shape(d)) & mask) == 7'b0) begin
                    hit = 1'b1;
                    mdl_bcd[m] = 4'(d);
                    mdl_cmp[m] = {seg[6], seg[5], seg[2], seg[1], seg[0]};
                end
            end
            exp_q[m].push_back('{bcd: mdl_bcd[m], val: hit, cmp: mdl_cmp[m]});
        end
        tag_q.push_back(tag);
        drive_word = w;
        in_strobe  = 1'b1;
        @(negedge clk);
        in_strobe  = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) pending <= in_strobe;

    // Monitor: compare both instances after each strobed edge.
    always @(negedge clk) begin
        if (pending && tag_q.size() > 0) begin
            exp_t  ef, er;
            string t;
            ef = exp_q[0].pop_front();
            er = exp_q[1].pop_front();
            t  = tag_q.pop_front();
            check({t, " full"}, {bcd_f, val_f, cmp_f}, ef);
            check({t, " reduced"}, {bcd_r, val_r, cmp_r}, er);
        end
    end

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [9:0] snap;
        mdl_bcd[0] = 0; mdl_bcd[1] = 0; mdl_cmp[0] = 0; mdl_cmp[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1 full", {bcd_f, val_f, cmp_f}, 10'h0);
        check("R1 reduced", {bcd_r, val_r, cmp_r}, 10'h0);

        // R2 and R7: common low, every digit
        for (int d = 0; d < 10; d++) apply({1'b0, shape(d)}, "R2_R7 common low");
        // R3: common high, complemented shapes
        for (int d = 9; d >= 0; d--) apply({1'b1, ~shape(d)}, "R3 common high");

        // R4: miss after a good digit holds the digit
        apply({1'b0, shape(6)}, "R4 setup");
        apply(8'b0_0000000, "R4 blank low");
        apply(8'b1_0000000, "R4 all lit high is 8");
        apply(8'b0_0000001, "R4 lone g");

        // R9 and R8: c or d disagree
        apply({1'b0, 7'b1110001}, "R8_R9 digit3 d off");
        apply({1'b1, ~7'b1001011}, "R8_R9 digit5 c off high");
        apply({1'b0, 7'b0101000}, "R8_R9 digit1 c off d on");

        // R5: wiggle input without strobe
        snap = {bcd_f, val_f, cmp_f};
        drive_word = {1'b0, shape(2)};
        @(negedge clk);
        drive_word = {1'b1, ~shape(4)};
        @(negedge clk);
        check("R5 hold full", {bcd_f, val_f, cmp_f}, snap);

        // R6: output unchanged before the capturing edge, updated after it
        apply({1'b0, shape(7)}, "R6 setup");
        snap = {bcd_f, val_f, cmp_f};
        drive_word = {1'b0, shape(4)};
        in_strobe  = 1'b1;
        @(posedge clk);
        #0.1;
        in_strobe = 1'b0;
        check("R6 after edge", {bcd_f, val_f, cmp_f}, {4'd4, 1'b1, 5'h0B});
        @(negedge clk);
        check("R6 before edge snapshot", snap, {4'd7, 1'b1, 5'h18});
        pending = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule